// File: doc/BRIEF.md
# Sleep Instruction Gate

This block sits between the core's instruction decoder and the clock and power controller. It decides whether a decoded STOP or WAIT request may put the CPU to sleep. If it may, the block passes on a one-cycle go pulse. If it may not, the request is dropped, the CPU keeps running, and a sticky flag records the refused attempt.

Each sleep instruction can be turned off in two ways. The first is a disable bit that software may set and clear at any time. The second is a lock bit that software can set but never clear; only a reset clears it. The block ORs the two. STOP also has a clock-safety rule. The PLL is never switched off by hardware, so stop with the PLL down is allowed only when the PLL is already off and the system clock is taken from the oscillator. A STOP that meets neither disable but finds the clock unsafe is refused, and it is flagged separately.

The control register is written through a plain write strobe with a data word, and it is read back combinationally. Bit layout: bit 0 stop soft disable, bit 1 wait soft disable, bit 2 stop lock, bit 3 wait lock, bit 4 stop-refused flag, bit 5 wait-refused flag, bit 6 clock-unsafe flag. Every bit above 6 reads 0. The pins carry no stream data, so they stay plain level and strobe signals with no back-pressure.

Top module: `sleep_gate`

## Requirements
- R1: After reset every register bit reads 0, and stop_go and wait_go are low.
- R2: A write with wr_en high loads bit 0 (stop soft disable) and bit 1 (wait soft disable) from wr_data. Either value is accepted, and the new value shows on rd_data from the next cycle.
- R3: Writing 1 to bit 2 (stop lock) or to bit 3 (wait lock) sets that lock. Writing 0 leaves it set. Only reset clears it.
- R4: The effective disable of each instruction is its soft bit OR its lock bit.
- R5: stop_go is high for exactly the cycle after a stop_req cycle, and only if stop is not disabled, pll_on is 0 and clk_sel_osc is 1.
- R6: wait_go is high for exactly the cycle after a wait_req cycle, and only if wait is not disabled. pll_on and clk_sel_osc have no effect on it.
- R7: A stop_req while stop is disabled produces no stop_go and sets bit 4 (stop-refused).
- R8: A wait_req while wait is disabled produces no wait_go and sets bit 5 (wait-refused).
- R9: A stop_req with stop not disabled but with pll_on=1 or clk_sel_osc=0 produces no stop_go. It sets bit 6 (clock-unsafe) and leaves bit 4 unchanged.
- R10: Bits 4 to 6 are write-1-to-clear. A set and a clear of the same flag in the same cycle leave the flag set.
- R11: Bits above 6 always read 0, and writing them has no effect.
- R12: A request is judged against the register contents as they stood before any write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | DATA_W | Control register write data |
| rd_data | output | DATA_W | Control register contents |
| stop_req | input | 1 | Decoded STOP instruction, one pulse |
| wait_req | input | 1 | Decoded WAIT instruction, one pulse |
| pll_on | input | 1 | PLL currently enabled |
| clk_sel_osc | input | 1 | System clock taken from the oscillator |
| stop_go | output | 1 | Stop entry granted, one-cycle pulse |
| wait_go | output | 1 | Wait entry granted, one-cycle pulse |

## Verification
The bench builds the block with DATA_W at its default of 8. That leaves one unused bit, bit 7, so writes to a bit above the defined field can be shown to have no effect. Directed sequences cover locks that resist clearing, a request that coincides with a write, and a flag set and cleared in the same cycle. A long stretch of pseudo-random writes, requests and clock settings then reaches mixed combinations of soft bits, locks and unsafe clocks, and a behavioural model checks the block against them every cycle.

// File: rtl/sleep_gate_pkg.sv
package sleep_gate_pkg;
  localparam int STOP_SOFT = 0;
  localparam int WAIT_SOFT = 1;
  localparam int STOP_LOCK = 2;
  localparam int WAIT_LOCK = 3;
  localparam int STOP_BLK  = 4;
  localparam int WAIT_BLK  = 5;
  localparam int CLK_BLK   = 6;
  localparam int USED_BITS = 7;
  localparam int NUM_FLAGS = 3;
  localparam int NUM_CH    = 2;
  localparam int CH_STOP   = 0;
  localparam int CH_WAIT   = 1;
endpackage

// File: rtl/sleep_dis_cell.sv
// One disable path: rewritable bit, sticky lock, and a registered go pulse.
module sleep_dis_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic soft_wd,
  input  logic lock_wd,
  input  logic req,
  input  logic cfg_ok,
  output logic soft_q,
  output logic lock_q,
  output logic go,
  output logic blk_dis,
  output logic blk_cfg
);
  logic dis;

  assign dis     = soft_q | lock_q;
  assign blk_dis = req & dis;
  assign blk_cfg = req & ~dis & ~cfg_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      soft_q <= 1'b0;
      lock_q <= 1'b0;
      go     <= 1'b0;
    end else begin
      go <= req & ~dis & cfg_ok;
      if (wr_en) begin
        soft_q <= soft_wd;
        lock_q <= lock_q | lock_wd;
      end
    end
  end
endmodule

// File: rtl/sleep_flags.sv
// Sticky refusal flags, write-1-to-clear, set wins over clear.
module sleep_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_v,
  input  logic [N-1:0] clr_v,
  output logic [N-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= (q & ~clr_v) | set_v;
  end
endmodule

// File: rtl/sleep_gate.sv
module sleep_gate
  import sleep_gate_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              stop_req,
  input  logic              wait_req,
  input  logic              pll_on,
  input  logic              clk_sel_osc,
  output logic              stop_go,
  output logic              wait_go
);
  localparam int HI_W = DATA_W - USED_BITS;

  logic [NUM_CH-1:0]    req_v, ok_v, soft_v, lock_v, go_v, bdis_v, bcfg_v;
  logic [NUM_FLAGS-1:0] fset, fclr, fq;
  logic                 clk_safe;
  logic                 unused_wr_hi;

  assign clk_safe       = ~pll_on & clk_sel_osc;
  assign req_v[CH_STOP] = stop_req;
  assign req_v[CH_WAIT] = wait_req;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    if (ch == CH_STOP) begin : g_cfg
      assign ok_v[ch] = clk_safe;
    end else begin : g_cfg
      assign ok_v[ch] = 1'b1;
    end
    sleep_dis_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .soft_wd (wr_data[STOP_SOFT + ch]),
      .lock_wd (wr_data[STOP_LOCK + ch]),
      .req     (req_v[ch]),
      .cfg_ok  (ok_v[ch]),
      .soft_q  (soft_v[ch]),
      .lock_q  (lock_v[ch]),
      .go      (go_v[ch]),
      .blk_dis (bdis_v[ch]),
      .blk_cfg (bcfg_v[ch])
    );
  end

  assign fset = {|bcfg_v, bdis_v[CH_WAIT], bdis_v[CH_STOP]};
  assign fclr = wr_en ? wr_data[CLK_BLK:STOP_BLK] : '0;

  sleep_flags #(.N(NUM_FLAGS)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .set_v (fset),
    .clr_v (fclr),
    .q     (fq)
  );

  assign unused_wr_hi = ^wr_data[DATA_W-1:USED_BITS];
  assign rd_data      = {{HI_W{1'b0}}, fq, lock_v, soft_v};
  assign stop_go      = go_v[CH_STOP];
  assign wait_go      = go_v[CH_WAIT];
endmodule

// File: rtl/sleep_gate_chk.sv
module sleep_gate_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic              stop_req,
  input logic              wait_req,
  input logic              pll_on,
  input logic              clk_sel_osc,
  input logic              stop_go,
  input logic              wait_go
);
  a_r3_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_data[2]) && $past(rd_data[3]) |-> rd_data[2] && rd_data[3]);

  a_r3_stop_lock_kept: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_data[2]) |-> rd_data[2]);

  a_r5_stop_go_legal: assert property (@(posedge clk) disable iff (!rst_n)
    stop_go |-> $past(stop_req && !rd_data[0] && !rd_data[2] && !pll_on && clk_sel_osc));

  a_r6_wait_go_legal: assert property (@(posedge clk) disable iff (!rst_n)
    wait_go |-> $past(wait_req && !rd_data[1] && !rd_data[3]));

  a_r7_stop_refused: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req && (rd_data[0] || rd_data[2]) |=> rd_data[4] && !stop_go);

  a_r8_wait_refused: assert property (@(posedge clk) disable iff (!rst_n)
    wait_req && (rd_data[1] || rd_data[3]) |=> rd_data[5] && !wait_go);

  a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_data[6]) && !$past(wr_en && wr_data[6]) |-> rd_data[6]);

  a_r11_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[DATA_W-1:7] == '0);
endmodule

bind sleep_gate sleep_gate_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_sleep_gate.sv
module tb_sleep_gate;
  localparam int DATA_W = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [DATA_W-1:0] rd_data;
  logic              stop_req = 1'b0, wait_req = 1'b0;
  logic              pll_on = 1'b0, clk_sel_osc = 1'b1;
  logic              stop_go, wait_go;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  sleep_gate #(.DATA_W(DATA_W)) dut (.*);

  // behavioural reference model
  bit m_ss, m_ws, m_sl, m_wl, m_fs, m_fw, m_fc, m_sg, m_wg;
  bit sdis, wdis, safe, n_sg, n_wg, s_fs, s_fw, s_fc;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {m_ss, m_ws, m_sl, m_wl, m_fs, m_fw, m_fc, m_sg, m_wg} = '0;
    end else begin
      sdis = m_ss || m_sl;
      wdis = m_ws || m_wl;
      safe = !pll_on && clk_sel_osc;
      n_sg = stop_req && !sdis && safe;
      n_wg = wait_req && !wdis;
      s_fs = stop_req && sdis;
      s_fw = wait_req && wdis;
      s_fc = stop_req && !sdis && !safe;
      if (wr_en) begin
        m_ss = wr_data[0];
        m_ws = wr_data[1];
        if (wr_data[2]) m_sl = 1;
        if (wr_data[3]) m_wl = 1;
        if (wr_data[4]) m_fs = 0;
        if (wr_data[5]) m_fw = 0;
        if (wr_data[6]) m_fc = 0;
      end
      if (s_fs) m_fs = 1;
      if (s_fw) m_fw = 1;
      if (s_fc) m_fc = 1;
      m_sg = n_sg;
      m_wg = n_wg;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check("R2 soft bits", int'(rd_data[1:0]), int'({m_ws, m_ss}));
    check("R3 lock bits", int'(rd_data[3:2]), int'({m_wl, m_sl}));
    check("R7 stop flag", int'(rd_data[4]), int'(m_fs));
    check("R8 wait flag", int'(rd_data[5]), int'(m_fw));
    check("R9 clock flag", int'(rd_data[6]), int'(m_fc));
    check("R11 upper bits", int'(rd_data[7]), 0);
    check("R5 stop_go", int'(stop_go), int'(m_sg));
    check("R6 wait_go", int'(wait_go), int'(m_wg));
  endtask

  // drive one cycle's inputs at a negedge, then compare at the following negedge
  task automatic step(input bit we, input logic [7:0] wd, input bit sr, input bit wr,
                      input bit pll, input bit osc);
    wr_en = we; wr_data = wd; stop_req = sr; wait_req = wr;
    pll_on = pll; clk_sel_osc = osc;
    @(negedge clk);
    compare_all();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset rd", int'(rd_data), 0);
    check("R1 reset go", int'({stop_go, wait_go}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5 / R6: plain grants
    step(0, 8'h00, 1, 0, 0, 1);
    check("R5 stop grant", int'(stop_go), 1);
    step(0, 8'h00, 0, 0, 0, 1);
    check("R5 single pulse", int'(stop_go), 0);
    step(0, 8'h00, 0, 1, 1, 0);
    check("R6 wait ignores clock", int'(wait_go), 1);

    // R9: unsafe clock
    step(0, 8'h00, 1, 0, 1, 1);
    check("R9 pll on blocks", int'({stop_go, rd_data[6], rd_data[4]}), 3'b010);
    step(1, 8'h40, 0, 0, 0, 1);
    check("R10 clear clock flag", int'(rd_data[6]), 0);

    // R12: write of soft disable in same cycle as request
    step(1, 8'h01, 1, 0, 0, 1);
    check("R12 pre-write judgement", int'(stop_go), 1);
    step(0, 8'h00, 1, 0, 0, 1);
    check("R7 soft refusal", int'({stop_go, rd_data[4]}), 2'b01);

    // R3 / R4: lock with soft cleared
    step(1, 8'h0C, 0, 0, 0, 1);
    step(1, 8'h00, 0, 1, 0, 1);
    check("R3 lock survives zero write", int'(rd_data[3:2]), 2'b11);
    step(0, 8'h00, 0, 0, 0, 1);
    check("R4 lock disables wait", int'({wait_go, rd_data[5]}), 2'b01);

    // R10: set and clear of same flag together
    step(1, 8'h20, 0, 1, 0, 1);
    check("R10 set wins", int'(rd_data[5]), 1);

    // R11: write upper bit
    step(1, 8'h80, 0, 0, 0, 1);
    check("R11 upper ignored", int'(rd_data[7]), 0);

    // reset clears locks (R3)
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R3 reset clears lock", int'(rd_data), 0);

    // pseudo-random traffic against model
    for (int i = 0; i < 600; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0] & r[1], r[15:8] & ((r[2] && r[3]) ? 8'hFF : 8'hF3),
           r[4], r[5], r[6] & r[7], ~(r[16] & r[17]));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule